// File: doc/BRIEF.md
# Link Bring-up and Acquisition Sequencer

This block sits at the back end of a serial link to a remote digitizer. It takes the link from power-on to a finished capture through eight phases, always in the same order. First it checks pattern lock. Next it measures the loopback round trip and switches the link to normal traffic. Then it issues one remote setup command, arms, captures on a trigger until told to stop, and finally plays the stored words out to a host port. Both ends run from one shared system clock. Because of that, the measured round trip and the capture timing are fixed numbers of cycles.

The link appears here as parallel words, each with a valid strobe. A small internal word store holds the capture. An abort input returns the sequence to the first phase at any time and clears the stored capture, the error flags and the latency value. The default parameters give a 16-bit word, a 16-word lock run, a 65535-cycle lock timeout, a 4096-cycle loopback timeout and a 1024-word store.

Top module: `link_acq_seq`

## Requirements
- R1: While reset is asserted and after its release, `phase_o` is 0 (lock check). In phase 0 the transmitter sends the pattern word 16'hBC5A with `tx_valid_o` high on every cycle. `link_normal_o`, `host_valid_o`, all three error flags and `latency_o` are 0.
- R2: Phase 0 moves to phase 1 on the clock edge that ends the SYNC_RUN-th consecutive received valid word equal to 16'hBC5A. A valid word with any other value restarts the run. Cycles with no valid word neither count toward the run nor restart it.
- R3: If SYNC_TMO cycles pass in phase 0 without a lock, `sync_err_o` is set at the edge that ends the SYNC_TMO-th cycle. The phase stays 0 and the run starts again.
- R4: In phase 1 the marker word 16'h3C7E is sent with valid only in the first cycle. `latency_o` takes the number of cycles from that cycle to the cycle in which the marker is received, and the next phase is 2.
- R5: If the marker has not been received by the LAT_TMO-th cycle of phase 1, `lat_err_o` is set and the sequencer returns to phase 0 one edge later. The phase-1 dwell is then exactly LAT_TMO cycles.
- R6: `link_normal_o` is high in phases 2 to 7. Phase 2 lasts one cycle. Phase 3 lasts one cycle, during which the setup command 16'h1A17 is sent with valid. Phase 4 follows.
- R7: Phase 4 waits for `trig_i`. Words received in phase 4 are not stored.
- R8: In phase 5 every valid received word is stored at the next address. `stop_i` leads to phase 6 for one cycle and then to phase 7.
- R9: If the store holds MEM_DEPTH words while in phase 5, `ovf_o` is set and the sequencer goes to phase 6 without a stop. Further words are dropped.
- R10: In phase 7 the stored words appear on `host_data_o` oldest first. Exactly as many words are shown as were stored. One word advances for each cycle with `host_valid_o` and `host_ready_i` both high. Data holds while ready is low, and `host_valid_o` falls after the last word.
- R11: `abort_i` in any phase gives phase 0 on the next cycle, with `sync_err_o`, `lat_err_o`, `ovf_o` and `latency_o` cleared and the store emptied.
- R12: The phase either holds or advances by exactly one step (phase 7 holds until abort). The only other change is a return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared with the remote end |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Return to phase 0 and clear results |
| tx_valid_o | output | 1 | Outgoing link word valid |
| tx_data_o | output | DATA_W | Outgoing link word |
| link_normal_o | output | 1 | Link in normal traffic mode |
| rx_valid_i | input | 1 | Incoming link word valid |
| rx_data_i | input | DATA_W | Incoming link word |
| trig_i | input | 1 | Start capture (phase 4) |
| stop_i | input | 1 | End capture (phase 5) |
| host_valid_o | output | 1 | Readout word available |
| host_ready_i | input | 1 | Host accepts readout word |
| host_data_o | output | DATA_W | Readout word |
| phase_o | output | 3 | Current phase code 0..7 |
| latency_o | output | LAT_W | Measured loopback cycles |
| sync_err_o | output | 1 | Lock timeout occurred |
| lat_err_o | output | 1 | Loopback timeout occurred |
| ovf_o | output | 1 | Store filled before stop |

## Verification
The phase register changes on the edge after the deciding input. So a lock, trigger, stop or abort driven in one cycle shows its new phase code in the following cycle. The bench sets each input on a falling edge and reads the result on the next falling edge. The transmit word, the readout word and `host_valid_o` follow the phase within the same cycle. They are read in the cycle their phase is first observed. The bench loopback is a register chain of D stages, so the expected latency is exactly D. The timeout checks count falling edges from the first cycle of the phase, giving 300 cycles to `sync_err_o` and 40 cycles of phase-1 dwell with the bench parameters.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [2:0] {
    PH_SYNC = 3'd0,
    PH_LAT  = 3'd1,
    PH_NORM = 3'd2,
    PH_INIT = 3'd3,
    PH_ARM  = 3'd4,
    PH_CAP  = 3'd5,
    PH_STOP = 3'd6,
    PH_DUMP = 3'd7
  } phase_e;
endpackage

// File: rtl/lsq_sync_chk.sv
module lsq_sync_chk #(
  parameter int                 DATA_W  = 16,
  parameter int                 RUN_LEN = 16,
  parameter int                 TMO_CYC = 65535,
  parameter logic [DATA_W-1:0]  PATTERN = 16'hBC5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              lock_o,
  output logic              tmo_o
);
  localparam int RW = $clog2(RUN_LEN + 1);
  localparam int TW = $clog2(TMO_CYC + 1);

  logic [RW-1:0] run_q, run_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          match;

  assign match  = rx_valid_i && (rx_data_i == PATTERN);
  assign lock_o = en_i && match && (run_q == RW'(RUN_LEN - 1));
  assign tmo_o  = en_i && !lock_o && (tmo_q == TW'(TMO_CYC - 1));

  always_comb begin
    run_d = run_q;
    tmo_d = tmo_q;
    if (!en_i || tmo_o || lock_o) begin
      run_d = '0;
      tmo_d = '0;
    end else begin
      tmo_d = tmo_q + 1'b1;
      if (rx_valid_i) begin
        run_d = match ? run_q + 1'b1 : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      tmo_q <= '0;
    end else begin
      run_q <= run_d;
      tmo_q <= tmo_d;
    end
  end

  // R2: the run never passes the lock length
  a_r2_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(RUN_LEN - 1));

  // R3: a timeout restarts the run
  a_r3_tmo_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_o |=> (run_q == '0) && (tmo_q == '0));
endmodule

// File: rtl/lsq_lat_meter.sv
module lsq_lat_meter #(
  parameter int                DATA_W  = 16,
  parameter int                TMO_CYC = 4096,
  parameter int                LAT_W   = 16,
  parameter logic [DATA_W-1:0] MARKER  = 16'h3C7E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              send_o,
  output logic              hit_o,
  output logic              tmo_o,
  output logic [LAT_W-1:0]  cnt_o
);
  localparam int CW = $clog2(TMO_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  assign send_o = en_i && (cnt_q == '0);
  assign hit_o  = en_i && rx_valid_i && (rx_data_i == MARKER);
  assign tmo_o  = en_i && !hit_o && (cnt_q == CW'(TMO_CYC - 1));
  assign cnt_o  = LAT_W'(cnt_q);

  always_comb begin
    cnt_d = '0;
    if (en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R4: marker goes out in one cycle only
  a_r4_single_marker: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |=> !send_o);
endmodule

// File: rtl/lsq_cap_mem.sv
module lsq_cap_mem #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_adv_i,
  output logic              full_o,
  output logic              rd_avail_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  wr_cnt_q, rd_ptr_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_cnt_q[AW-1:0]] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt_q <= '0;
    end else if (clr_i) begin
      wr_cnt_q <= '0;
    end else if (wr_en_i) begin
      wr_cnt_q <= wr_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
    end else if (clr_i) begin
      rd_ptr_q <= '0;
    end else if (rd_adv_i) begin
      rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign full_o     = (wr_cnt_q == CNT_W'(DEPTH));
  assign rd_avail_o = (rd_ptr_q != wr_cnt_q);
  assign rd_data_o  = mem_q[rd_ptr_q[AW-1:0]];

  // R9: the sequencer never writes a full store
  a_r9_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> !full_o);

  // R10: readout never advances past the stored count
  a_r10_no_read_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv_i |-> rd_avail_o);
endmodule

// File: rtl/link_acq_seq.sv
module link_acq_seq
  import lsq_pkg::*;
#(
  parameter int                DATA_W      = 16,
  parameter int                SYNC_RUN    = 16,
  parameter int                SYNC_TMO    = 65535,
  parameter int                LAT_TMO     = 4096,
  parameter int                LAT_W       = 16,
  parameter int                MEM_DEPTH   = 1024,
  parameter logic [DATA_W-1:0] SYNC_WORD   = 16'hBC5A,
  parameter logic [DATA_W-1:0] MARKER_WORD = 16'h3C7E,
  parameter logic [DATA_W-1:0] SETUP_WORD  = 16'h1A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              link_normal_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              trig_i,
  input  logic              stop_i,
  output logic              host_valid_o,
  input  logic              host_ready_i,
  output logic [DATA_W-1:0] host_data_o,
  output logic [2:0]        phase_o,
  output logic [LAT_W-1:0]  latency_o,
  output logic              sync_err_o,
  output logic              lat_err_o,
  output logic              ovf_o
);
  phase_e            ph_q, ph_d;
  logic [2:0]        ph_bits;
  logic              sync_en, lock, sync_tmo;
  logic              lat_en, send_mark, lat_hit, lat_tmo;
  logic [LAT_W-1:0]  lat_cnt;
  logic              wr_en, rd_adv, full, rd_avail;
  logic [DATA_W-1:0] rd_data;
  logic              sync_err_q, lat_err_q, ovf_q;
  logic [LAT_W-1:0]  lat_q;

  assign sync_en = (ph_q == PH_SYNC) && !abort_i;
  assign lat_en  = (ph_q == PH_LAT) && !abort_i;
  assign wr_en   = (ph_q == PH_CAP) && rx_valid_i && !full && !abort_i;
  assign rd_adv  = host_valid_o && host_ready_i && !abort_i;

  lsq_sync_chk #(
    .DATA_W (DATA_W),
    .RUN_LEN(SYNC_RUN),
    .TMO_CYC(SYNC_TMO),
    .PATTERN(SYNC_WORD)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (sync_en),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .lock_o    (lock),
    .tmo_o     (sync_tmo)
  );

  lsq_lat_meter #(
    .DATA_W (DATA_W),
    .TMO_CYC(LAT_TMO),
    .LAT_W  (LAT_W),
    .MARKER (MARKER_WORD)
  ) u_lat (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (lat_en),
    .rx_valid_i(rx_valid_i),
    .rx_data_i (rx_data_i),
    .send_o    (send_mark),
    .hit_o     (lat_hit),
    .tmo_o     (lat_tmo),
    .cnt_o     (lat_cnt)
  );

  lsq_cap_mem #(
    .DATA_W(DATA_W),
    .DEPTH (MEM_DEPTH)
  ) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (abort_i),
    .wr_en_i   (wr_en),
    .wr_data_i (rx_data_i),
    .rd_adv_i  (rd_adv),
    .full_o    (full),
    .rd_avail_o(rd_avail),
    .rd_data_o (rd_data)
  );

  // next phase
  always_comb begin
    ph_d = ph_q;
    if (abort_i) begin
      ph_d = PH_SYNC;
    end else begin
      case (ph_q)
        PH_SYNC: if (lock) ph_d = PH_LAT;
        PH_LAT: begin
          if (lat_hit)      ph_d = PH_NORM;
          else if (lat_tmo) ph_d = PH_SYNC;
        end
        PH_NORM: ph_d = PH_INIT;
        PH_INIT: ph_d = PH_ARM;
        PH_ARM:  if (trig_i) ph_d = PH_CAP;
        PH_CAP:  if (stop_i || full) ph_d = PH_STOP;
        PH_STOP: ph_d = PH_DUMP;
        PH_DUMP: ph_d = PH_DUMP;
        default: ph_d = PH_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_SYNC;
    end else begin
      ph_q <= ph_d;
    end
  end

  // result flags and latency, each with its own enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_err_q <= 1'b0;
    end else if (abort_i) begin
      sync_err_q <= 1'b0;
    end else if (sync_tmo) begin
      sync_err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_err_q <= 1'b0;
    end else if (abort_i) begin
      lat_err_q <= 1'b0;
    end else if (lat_tmo) begin
      lat_err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (abort_i) begin
      lat_q <= '0;
    end else if (lat_hit) begin
      lat_q <= lat_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else if (abort_i) begin
      ovf_q <= 1'b0;
    end else if ((ph_q == PH_CAP) && full) begin
      ovf_q <= 1'b1;
    end
  end

  // transmit word per phase
  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = '0;
    case (ph_q)
      PH_SYNC: begin
        tx_valid_o = 1'b1;
        tx_data_o  = SYNC_WORD;
      end
      PH_LAT: begin
        tx_valid_o = send_mark;
        tx_data_o  = send_mark ? MARKER_WORD : '0;
      end
      PH_INIT: begin
        tx_valid_o = 1'b1;
        tx_data_o  = SETUP_WORD;
      end
      default: begin
        tx_valid_o = 1'b0;
        tx_data_o  = '0;
      end
    endcase
  end

  assign ph_bits       = ph_q;
  assign phase_o       = ph_bits;
  assign link_normal_o = (ph_q != PH_SYNC) && (ph_q != PH_LAT);
  assign host_valid_o  = (ph_q == PH_DUMP) && rd_avail;
  assign host_data_o   = rd_data;
  assign latency_o     = lat_q;
  assign sync_err_o    = sync_err_q;
  assign lat_err_o     = lat_err_q;
  assign ovf_o         = ovf_q;

  // R12: phase holds, steps by one, or returns to 0
  a_r12_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_bits != $past(ph_bits)) |->
      ((ph_bits == $past(ph_bits) + 3'd1) || (ph_bits == 3'd0)));

  // R11: abort empties results and restarts
  a_r11_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (ph_q == PH_SYNC) && !sync_err_o && !lat_err_o && !ovf_o && (latency_o == '0));

  // R2: leaving lock check follows a matching received word
  a_r2_lock_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_LAT) && ($past(ph_q) == PH_SYNC)) |->
      $past(rx_valid_i && (rx_data_i == SYNC_WORD)));

  // R6: setup phase lasts a single cycle
  a_r6_setup_once: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_INIT) |=> (ph_q == PH_ARM) || (ph_q == PH_SYNC));

  // R7: capture begins only on a trigger
  a_r7_capture_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_CAP) && ($past(ph_q) == PH_ARM)) |-> $past(trig_i));

  // R10: readout word holds while the host stalls
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (host_valid_o && !host_ready_i && !abort_i) |=> host_valid_o && $stable(host_data_o));
endmodule

// File: tb/test_link_acq_seq.sv
module test_link_acq_seq;
  localparam int DW       = 16;
  localparam int T_RUN    = 16;
  localparam int T_STMO   = 300;
  localparam int T_LTMO   = 40;
  localparam int T_DEPTH  = 8;
  localparam logic [DW-1:0] W_SYNC  = 16'hBC5A;
  localparam logic [DW-1:0] W_MARK  = 16'h3C7E;
  localparam logic [DW-1:0] W_SETUP = 16'h1A17;

  // {loop delay, words to capture, first word value}
  localparam logic [31:0] VEC [4] = '{
    {8'd1, 8'd3, 16'h1000},
    {8'd3, 8'd5, 16'h2200},
    {8'd5, 8'd7, 16'h3300},
    {8'd7, 8'd1, 16'h4400}
  };

  logic          clk, rst_n, abort, trig, stop, host_ready;
  logic          tx_valid, link_normal, rx_valid, host_valid;
  logic          sync_err, lat_err, ovf;
  logic [DW-1:0] tx_data, rx_data, host_data;
  logic [2:0]    phase;
  logic [15:0]   latency;

  logic          lb_en, drv_valid;
  logic [DW-1:0] drv_data;
  int            lb_delay;
  logic [DW:0]   dl [8];

  int tests, fails;

  link_acq_seq #(
    .SYNC_RUN (T_RUN),
    .SYNC_TMO (T_STMO),
    .LAT_TMO  (T_LTMO),
    .MEM_DEPTH(T_DEPTH)
  ) i_link_acq_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort_i      (abort),
    .tx_valid_o   (tx_valid),
    .tx_data_o    (tx_data),
    .link_normal_o(link_normal),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .trig_i       (trig),
    .stop_i       (stop),
    .host_valid_o (host_valid),
    .host_ready_i (host_ready),
    .host_data_o  (host_data),
    .phase_o      (phase),
    .latency_o    (latency),
    .sync_err_o   (sync_err),
    .lat_err_o    (lat_err),
    .ovf_o        (ovf)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // loopback model: register chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) dl[i] <= '0;
    end else begin
      dl[0] <= {tx_valid, tx_data};
      for (int i = 1; i < 8; i++) dl[i] <= dl[i-1];
    end
  end

  always_comb begin
    if (lb_en) begin
      rx_valid = dl[lb_delay-1][DW];
      rx_data  = dl[lb_delay-1][DW-1:0];
    end else begin
      rx_valid = drv_valid;
      rx_data  = drv_data;
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_abort();
    abort = 1'b1;
    step();
    abort = 1'b0;
  endtask

  task automatic bring_up(input int d);
    int n;
    lb_en    = 1'b1;
    lb_delay = d;
    do_abort();
    chk(phase == 3'd0 && !lat_err && !sync_err && latency == 16'd0, "R11 abort to phase 0", phase, 0);
    n = 0;
    while (phase != 3'd1 && n < 100) begin step(); n++; end
    chk(phase == 3'd1, "R2 lock via loopback", phase, 1);
    chk(tx_valid && tx_data == W_MARK, "R4 marker sent", tx_data, W_MARK);
    step();
    chk(!tx_valid, "R4 marker only once", tx_valid, 0);
    n = 0;
    while (phase != 3'd2 && n < 60) begin step(); n++; end
    chk(latency == 16'(d), "R4 latency", latency, d);
    chk(phase == 3'd2 && link_normal, "R6 normal mode", phase, 2);
    step();
    chk(phase == 3'd3 && tx_valid && tx_data == W_SETUP, "R6 setup command", tx_data, W_SETUP);
    step();
    chk(phase == 3'd4, "R6 armed after setup", phase, 4);
    lb_en = 1'b0;
  endtask

  task automatic start_capture();
    drv_valid = 1'b1;
    drv_data  = 16'hDEAD;
    step();
    step();
    chk(phase == 3'd4, "R7 waits for trigger", phase, 4);
    drv_valid = 1'b0;
    trig = 1'b1;
    step();
    trig = 1'b0;
    chk(phase == 3'd5, "R8 capture on trigger", phase, 5);
  endtask

  task automatic dump_check(input int n, input logic [DW-1:0] base);
    int got;
    logic [DW-1:0] d0;
    host_ready = 1'b0;
    d0 = host_data;
    step();
    step();
    chk(host_valid == (n > 0) && host_data == d0, "R10 hold while stalled", host_data, d0);
    got = 0;
    for (int c = 0; c < 40; c++) begin
      host_ready = (c % 3) != 2;
      if (host_valid && host_ready) begin
        chk(host_data == base + DW'(got), "R10 readout order", host_data, base + DW'(got));
        got++;
      end
      step();
    end
    host_ready = 1'b0;
    chk(got == n, "R10 word count", got, n);
    chk(!host_valid && phase == 3'd7, "R10 valid falls after last", host_valid, 0);
  endtask

  initial begin
    tests = 0; fails = 0;
    rst_n = 1'b0; abort = 1'b0; trig = 1'b0; stop = 1'b0; host_ready = 1'b0;
    lb_en = 1'b0; lb_delay = 1; drv_valid = 1'b0; drv_data = '0;
    step();
    chk(phase == 3'd0 && tx_valid && tx_data == W_SYNC, "R1 reset phase and pattern", tx_data, W_SYNC);
    step();
    rst_n = 1'b1;
    step();
    chk(!link_normal && !host_valid && !sync_err && !lat_err && !ovf && latency == 16'd0,
        "R1 outputs after reset", {link_normal, host_valid, sync_err, lat_err, ovf}, 0);

    // R2 run restart, then R5 loopback timeout
    do_abort();
    for (int i = 0; i < 15; i++) begin drv_valid = 1'b1; drv_data = W_SYNC; step(); end
    drv_data = 16'h0000;
    step();
    drv_valid = 1'b0;
    step();
    for (int i = 0; i < 15; i++) begin drv_valid = 1'b1; drv_data = W_SYNC; step(); end
    chk(phase == 3'd0, "R2 mismatch restarts run", phase, 0);
    step();
    drv_valid = 1'b0;
    chk(phase == 3'd1, "R2 lock after run", phase, 1);
    begin
      int k = 0;
      while (phase == 3'd1 && k < 100) begin step(); k++; end
      chk(k == T_LTMO, "R5 phase 1 dwell", k, T_LTMO);
      chk(phase == 3'd0 && lat_err, "R5 error and return", {phase, lat_err}, 1);
    end

    // R3 lock timeout
    do_abort();
    chk(!lat_err, "R11 abort clears loop error", lat_err, 0);
    begin
      int k = 0;
      while (!sync_err && k < 400) begin step(); k++; end
      chk(k == T_STMO && phase == 3'd0, "R3 timeout cycle", k, T_STMO);
    end

    // table of delays and capture lengths
    for (int v = 0; v < 4; v++) begin
      int d, n;
      logic [DW-1:0] base;
      d    = int'(VEC[v][31:24]);
      n    = int'(VEC[v][23:16]);
      base = VEC[v][15:0];
      bring_up(d);
      start_capture();
      for (int i = 0; i < n; i++) begin
        drv_valid = 1'b1;
        drv_data  = base + DW'(i);
        step();
        if (i == 0) begin drv_valid = 1'b0; step(); end
      end
      drv_valid = 1'b0;
      stop = 1'b1;
      step();
      stop = 1'b0;
      chk(phase == 3'd6, "R8 stop phase", phase, 6);
      step();
      chk(phase == 3'd7 && !ovf, "R8 readout phase", phase, 7);
      dump_check(n, base);
    end

    // R9 overflow without stop
    bring_up(2);
    start_capture();
    for (int i = 0; i < 10; i++) begin
      drv_valid = 1'b1;
      drv_data  = 16'h5000 + DW'(i);
      step();
    end
    drv_valid = 1'b0;
    chk(ovf && phase == 3'd7, "R9 overflow ends capture", {ovf, phase}, 4'hF);
    dump_check(T_DEPTH, 16'h5000);

    // R11 abort from readout
    do_abort();
    chk(phase == 3'd0 && !ovf && latency == 16'd0 && !host_valid, "R11 abort clears results",
        {phase, ovf, host_valid}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule